// File: doc/BRIEF.md
# Byte-Multiplexed Sample Output Formatter

This block sits at the end of a 16-bit conversion pipeline. It accepts one result per sample slot and shows it on a narrow 8-bit bus as two bytes, upper half first. A sample slot is two cycles of the internal clock `clk`, which runs at twice the sample rate. In the first cycle of each slot the upper byte is driven, and in the second cycle the lower byte is driven. A fixed delay of nine slots separates a result entering the block from its bytes appearing on the bus. This delay stands for the latency of the converter pipeline, so each byte lines up with the sample clock seen by the consumer.

A small two-state machine tracks the byte phase. State `PH_HI` is the upper-byte cycle and state `PH_LO` is the lower-byte cycle. Transition `PH_HI -> PH_LO` happens on every clock edge. Transition `PH_LO -> PH_HI` also happens on every clock edge and closes a slot; on that edge the delay line advances by one slot. Reset forces `PH_HI`.

A narrow-output mode keeps only the eight most significant bits: the upper byte fills both halves of the slot, and the lower byte never reaches the bus. An active-low enable releases the bus to high impedance. It has no effect on the flow of samples through the delay line.

Top module: `byte_mux_fmt`

## Requirements
- R1: With the narrow-output mode bit `one_byte` low, a valid result is shown in its output slot as two bytes: the upper byte (bits 15:8) in the first cycle and the lower byte (bits 7:0) in the second cycle.
- R2: After reset is released, the first clock cycle is an upper-byte cycle. From then on, upper-byte and lower-byte cycles alternate on every clock edge.
- R3: With `one_byte` high, both cycles of an output slot carry bits 15:8 of the result, and bits 7:0 never appear on the bus.
- R4: A result presented in slot s comes out in slot s+9. A slot begins with its upper-byte cycle.
- R5: While `oe_n` is high, all eight bits of `dout` are high impedance. While `oe_n` is low, the bus is driven. The enable takes effect in the same cycle it changes.
- R6: On `dout`, bit 7 carries the most significant bit and bit 0 the least significant bit of the byte being shown, so the result 16'h8001 appears as 8'h80 followed by 8'h01.
- R7: A slot whose input had `smp_valid` low shows 8'h00 in both cycles. After reset, the first nine slots show 8'h00.
- R8: The input pair `smp_valid`/`smp_data` is captured only on the clock edge that ends the lower-byte cycle. Values held only during the upper-byte cycle have no effect.
- R9: Holding `oe_n` high does not stall or drop samples. Results entered while the bus was released come out at their normal slot once the bus is enabled.
- R10: `one_byte` is applied when a result is output, not when it is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Marks `smp_data` as a real result for this slot |
| smp_data | input | 16 | Conversion result |
| one_byte | input | 1 | 1 = output only the upper byte; 0 = output both bytes (default) |
| oe_n | input | 1 | Active-low output enable; high releases `dout` |
| dout | output | 8 | Byte-multiplexed output bus |

## Verification
A result presented in slot s must show its upper byte in clock cycle 2(s+9) after reset release and its lower byte in cycle 2(s+9)+1. The bench counts slots from the reset release edge and keeps the last sixteen inputs in a ring. For every slot it predicts both bytes from the input of slot s-9, and from zero while s is below 9. The bench drives inputs on the falling edge that starts a slot and samples `dout` on the falling edge inside each half. Each sample is taken one register stage after the capture edge, so a single-cycle slip in the delay line or the phase machine changes the compared byte. `oe_n` and `one_byte` act combinationally, so the bench predicts them from their values in the cycle being checked.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;
    // Byte phase of the output bus: upper half then lower half of a slot.
    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;

    // Pick one half of a result; hi=1 returns the upper half.
    function automatic logic [7:0] pick_half8(input logic [15:0] word, input logic hi);
        return hi ? word[15:8] : word[7:0];
    endfunction
endpackage

// File: rtl/fmt_phase_fsm.sv
`timescale 1ns/1ps
module fmt_phase_fsm
    import fmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   slot_end_o
);

    phase_e st_q;
    phase_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PH_HI;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_HI:   st_d = PH_LO;
            PH_LO:   st_d = PH_HI;
            default: st_d = PH_HI;
        endcase
    end

    // Outputs
    always_comb begin
        phase_o    = st_q;
        slot_end_o = 1'b0;
        unique case (st_q)
            PH_HI:   slot_end_o = 1'b0;
            PH_LO:   slot_end_o = 1'b1;
            default: slot_end_o = 1'b0;
        endcase
    end

    // R2: upper-byte cycle is always followed by a lower-byte cycle
    p_hi_then_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HI) |=> (st_q == PH_LO));

    // R2: lower-byte cycle is always followed by an upper-byte cycle
    p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_LO) |=> (st_q == PH_HI));

endmodule

// File: rtl/fmt_delay_line.sv
`timescale 1ns/1ps
module fmt_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    localparam int LAST = DEPTH - 1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic         v_r;
        logic [W-1:0] d_r;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_r <= 1'b0;
                    d_r <= '0;
                end else if (shift_en) begin
                    v_r <= in_v;
                    d_r <= in_d;
                end
            end

            // R8: the first stage only changes on the slot-closing edge
            p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> ($stable(v_r) && $stable(d_r)));
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_r <= 1'b0;
                    d_r <= '0;
                end else if (shift_en) begin
                    v_r <= g_stage[i-1].v_r;
                    d_r <= g_stage[i-1].d_r;
                end
            end

            // R4: each stage takes its neighbour's content once per slot
            p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> ((v_r == $past(g_stage[i-1].v_r)) &&
                              (d_r == $past(g_stage[i-1].d_r))));
        end
    end

    assign out_v = g_stage[LAST].v_r;
    assign out_d = g_stage[LAST].d_r;

endmodule

// File: rtl/fmt_byte_sel.sv
`timescale 1ns/1ps
module fmt_byte_sel
    import fmt_pkg::*;
#(
    parameter int W = 16
) (
    input  phase_e         phase,
    input  logic           one_byte,
    input  logic           tail_v,
    input  logic [W-1:0]   tail_d,
    output logic [W/2-1:0] byte_o
);

    localparam int BW = W / 2;

    logic [BW-1:0] upper;
    logic [BW-1:0] lower;

    assign upper = tail_d[W-1 -: BW];
    assign lower = tail_d[BW-1:0];

    always_comb begin
        byte_o = '0;
        if (tail_v) begin
            unique case (phase)
                PH_HI:   byte_o = upper;
                PH_LO:   byte_o = one_byte ? upper : lower;
                default: byte_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/byte_mux_fmt.sv
`timescale 1ns/1ps
module byte_mux_fmt
    import fmt_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int LATENCY  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [SAMPLE_W-1:0]   smp_data,
    input  logic                  one_byte,
    input  logic                  oe_n,
    output logic [SAMPLE_W/2-1:0] dout
);

    localparam int BW = SAMPLE_W / 2;

    phase_e              phase;
    logic                slot_end;
    logic                tail_v;
    logic [SAMPLE_W-1:0] tail_d;
    logic [BW-1:0]       drv_byte;

    fmt_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .slot_end_o (slot_end)
    );

    fmt_delay_line #(
        .W     (SAMPLE_W),
        .DEPTH (LATENCY)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (slot_end),
        .in_v     (smp_valid),
        .in_d     (smp_data),
        .out_v    (tail_v),
        .out_d    (tail_d)
    );

    fmt_byte_sel #(
        .W (SAMPLE_W)
    ) u_sel (
        .phase    (phase),
        .one_byte (one_byte),
        .tail_v   (tail_v),
        .tail_d   (tail_d),
        .byte_o   (drv_byte)
    );

    assign dout = oe_n ? {BW{1'bz}} : drv_byte;

    // R1: upper half of the delayed result in the first cycle of a slot
    p_upper_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_v && phase == PH_HI) |-> (drv_byte == tail_d[SAMPLE_W-1 -: BW]));

    // R3: narrow mode never lets the lower half out
    p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_v && one_byte) |-> (drv_byte == pick_half8(tail_d, 1'b1)));

    // R7: empty slots produce a zero byte
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_v |-> (drv_byte == '0));

endmodule

// File: tb/tb_byte_mux_fmt.sv
`timescale 1ns/1ps
module tb_byte_mux_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        one_byte = 1'b0;
    logic        oe_n = 1'b0;
    wire  [7:0]  dout;

    int total = 0;
    int bad = 0;
    int slot = 0;
    logic        ring_v [16];
    logic [15:0] ring_d [16];

    always #2.5 clk = ~clk;

    byte_mux_fmt dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .one_byte  (one_byte),
        .oe_n      (oe_n),
        .dout      (dout)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s slot=%0d got=%h exp=%h", tag, slot, got, exp);
        end
    endtask

    // One sample slot. Entry and exit at the falling edge that starts a slot.
    // late=1: the HI cycle carries a decoy value, the real one is set for LO (R8).
    task automatic do_slot(input string tag, input logic v, input logic [15:0] d,
                           input logic ob, input logic oe, input logic late);
        logic [7:0]  eh;
        logic [7:0]  el;
        logic        pv;
        logic [15:0] pd;
        ring_v[slot % 16] = v;
        ring_d[slot % 16] = d;
        pv = (slot >= 9) ? ring_v[(slot - 9) % 16] : 1'b0;
        pd = (slot >= 9) ? ring_d[(slot - 9) % 16] : 16'h0000;
        one_byte  = ob;
        oe_n      = oe;
        smp_valid = late ? ~v : v;
        smp_data  = late ? ~d : d;
        eh = pv ? pd[15:8] : 8'h00;
        el = pv ? (ob ? pd[15:8] : pd[7:0]) : 8'h00;
        if (oe) begin
            eh = 8'hzz;
            el = 8'hzz;
        end
        #1;
        chk({tag, " hi"}, dout, eh);
        @(posedge clk);
        @(negedge clk);
        smp_valid = v;
        smp_data  = d;
        #1;
        chk({tag, " lo"}, dout, el);
        @(posedge clk);
        @(negedge clk);
        slot++;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset zero", dout, 8'h00);
        oe_n = 1'b1;
        #1;
        chk("R5 reset hiz", dout, 8'hzz);
        oe_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        slot = 0;
    endtask

    // R7 R2 R4: pipeline starts empty for nine slots, then the first sample lands.
    task automatic t_fill();
        do_slot("R7 R4 fill", 1'b1, 16'h8001, 1'b0, 1'b0, 1'b0);
        do_slot("R7 R4 fill", 1'b1, 16'hA55A, 1'b0, 1'b0, 1'b0);
        do_slot("R7 R4 fill", 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++)
            do_slot("R7 R4 fill", 1'b1, 16'h0F00 + 16'(i), 1'b0, 1'b0, 1'b0);
    endtask

    // R1 R6 R2: two-byte stream with distinct patterns
    task automatic t_two_byte();
        do_slot("R1 R6", 1'b1, 16'hFF00, 1'b0, 1'b0, 1'b0);
        do_slot("R1 R6", 1'b1, 16'h00FF, 1'b0, 1'b0, 1'b0);
        do_slot("R1 R6", 1'b1, 16'h0180, 1'b0, 1'b0, 1'b0);
        do_slot("R1 R6", 1'b1, 16'hC3E7, 1'b0, 1'b0, 1'b0);
    endtask

    // R3 R10: narrow mode applied at output time
    task automatic t_one_byte();
        for (int i = 0; i < 5; i++)
            do_slot("R3 R10", 1'b1, 16'h7E00 | 16'(i * 17), 1'b1, 1'b0, 1'b0);
        do_slot("R10 off", 1'b1, 16'h2468, 1'b0, 1'b0, 1'b0);
        do_slot("R10 on", 1'b1, 16'h1357, 1'b1, 1'b0, 1'b0);
    endtask

    // R7: gaps in the valid stream
    task automatic t_gaps();
        do_slot("R7 gap", 1'b0, 16'hDEAD, 1'b0, 1'b0, 1'b0);
        do_slot("R7 gap", 1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b0);
        do_slot("R7 gap", 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        do_slot("R7 gap", 1'b1, 16'h0001, 1'b0, 1'b0, 1'b0);
    endtask

    // R5 R9: bus released for several slots, samples keep flowing
    task automatic t_oe();
        for (int i = 0; i < 4; i++)
            do_slot("R5 R9", 1'b1, 16'h5A00 + 16'(i), 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)
            do_slot("R9", 1'b1, 16'h3300 + 16'(i), 1'b0, 1'b0, 1'b0);
    endtask

    // R8: decoy values during the upper-byte cycle are not captured
    task automatic t_capture();
        do_slot("R8", 1'b1, 16'h6C39, 1'b0, 1'b0, 1'b1);
        do_slot("R8", 1'b0, 16'h9999, 1'b0, 1'b0, 1'b1);
        do_slot("R8", 1'b1, 16'h00A5, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 10; i++)
            do_slot("R4 R7 flush", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_two_byte();
        t_one_byte();
        t_gaps();
        t_oe();
        t_capture();
        t_flush();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule